// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder

This block adds two unsigned operands of `W` bits with a single one-bit full-adder cell, one bit position per clock. A start pulse copies both operands in parallel into two right-shifting registers and clears a one-bit carry register. On every following add cycle, the full adder combines the low bits of both operand registers with the stored carry. On that same clock edge, the operand registers shift right, the sum bit enters the top of a third shift register and the carry-out is written back into the carry register.

After exactly `W` add cycles the block drops `busy`, raises `done` for one clock and presents the `W`-bit sum together with the final carry as a `W+1`-bit result. The result holds until the next accepted start. The block is meant for places where area counts for more than latency. It replaces a `W`-cell ripple chain with one cell, a flip-flop and a bit counter.

Top module: `bitser_add`

## Requirements
- R1: A synchronous active-high `rst` clears `busy`, `done`, `sum_out` and `carry_out` to 0, and this includes a reset that arrives in the middle of an addition.
- R2: When `start` is high at a clock edge while `busy` is low, `a_in` and `b_in` are captured on that edge and `busy` is high from the next cycle.
- R3: `busy` stays high for exactly `W` cycles after an accepted start. In the cycle after the last add cycle, `busy` is low and `done` is high.
- R4: `done` is high for exactly one clock cycle per accepted start.
- R5: While `done` is high, `{carry_out, sum_out}` equals the unsigned `W+1`-bit sum of the captured operands. Bit positions are added least significant first.
- R6: A `start` pulse while `busy` is high is ignored. Neither the result nor the timing of the addition in progress changes.
- R7: Once `busy` has fallen, `sum_out` and `carry_out` keep their values until the next accepted start.
- R8: An accepted start clears the stored carry, so a carry left by the previous addition does not enter the next one.
- R9: A start in the same cycle as `done` is accepted and begins a new addition at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load operands and begin an addition |
| a_in | input | W | First operand, sampled on an accepted start |
| b_in | input | W | Second operand, sampled on an accepted start |
| busy | output | 1 | High while add cycles are in progress |
| done | output | 1 | One-cycle pulse once the result is complete |
| sum_out | output | W | Low `W` bits of the result |
| carry_out | output | 1 | Most significant bit of the result |

## Verification
A bit counter that is off by one shows up on the `done` pulse. It arrives a cycle early or late, and because the sum register has then shifted too few or too many times, the result appears rotated or scaled by two. The bench therefore samples `busy` in every add cycle and checks the result in the exact cycle of `done`. A stale or stuck carry register corrupts only the operand pairs whose additions propagate a carry, so the random pairs are mixed with all-ones and carry-chain corner cases. A full-width overflow is also followed directly by a zero addition, which shows a leftover carry in the very next result. Operand registers that accept a start while busy change the result of the addition already in progress, so a mid-addition start with different operands is exercised.

// File: rtl/bitser_pkg.sv
package bitser_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/bitser_fa.sv
module bitser_fa (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    logic half;
    always_comb begin
        half = x ^ y;
        s    = half ^ cin;
        cout = (x & y) | (half & cin);
    end
endmodule

// File: rtl/bitser_shreg.sv
module bitser_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] par_out
);
    typedef struct packed {
        logic [W-1:0] data;
    } sr_t;

    sr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.data = par_in;
        end else if (shift) begin
            st_d.data = {ser_in, st_q.data[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign par_out = st_q.data;
endmodule

// File: rtl/bitser_ctrl.sv
module bitser_ctrl
    import bitser_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic shift,
    output logic busy,
    output logic done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          done;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = 1'b0;
        shift     = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    st_d.ph  = PH_RUN;
                    st_d.cnt = '0;
                end
            end
            PH_RUN: begin
                shift = 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{ph: PH_IDLE, cnt: '0, done: 1'b0};
        else     st_q <= st_d;
    end

    assign busy = (st_q.ph == PH_RUN);
    assign done = st_q.done;
endmodule

// File: rtl/bitser_add.sv
module bitser_add #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] sum_out,
    output logic         carry_out
);
    logic         load, shift;
    logic [W-1:0] a_reg, b_reg;
    logic         bit_s, bit_c;

    typedef struct packed {
        logic cy;
    } cy_t;

    cy_t cy_d, cy_q;

    bitser_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .shift(shift), .busy(busy), .done(done)
    );

    bitser_shreg #(.W(W)) u_opa (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .par_in(a_in), .ser_in(1'b0), .par_out(a_reg)
    );

    bitser_shreg #(.W(W)) u_opb (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .par_in(b_in), .ser_in(1'b0), .par_out(b_reg)
    );

    bitser_fa u_fa (
        .x(a_reg[0]), .y(b_reg[0]), .cin(cy_q.cy),
        .s(bit_s), .cout(bit_c)
    );

    bitser_shreg #(.W(W)) u_sum (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .par_in({W{1'b0}}), .ser_in(bit_s), .par_out(sum_out)
    );

    always_comb begin
        cy_d = cy_q;
        if (load)       cy_d.cy = 1'b0;
        else if (shift) cy_d.cy = bit_c;
    end

    always_ff @(posedge clk) begin
        if (rst) cy_q <= '0;
        else     cy_q <= cy_d;
    end

    assign carry_out = cy_q.cy;
endmodule

// File: rtl/bitser_add_chk.sv
module bitser_add_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] sum_out,
    input logic         carry_out
);
    localparam int BW = $clog2(W + 2);

    logic [BW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)                run_cnt <= '0;
        else if (start && !busy) run_cnt <= '0;
        else if (busy)           run_cnt <= run_cnt + 1'b1;
    end

    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy) else $error("start not taken"); // R2

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == BW'(W))) else $error("run length wrong"); // R3

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))) else $error("done without run"); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done too long"); // R4

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (busy && start && run_cnt < BW'(W - 1)) |=> busy) else $error("start cut run"); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(sum_out) && $stable(carry_out))) else $error("result moved"); // R7
endmodule

bind bitser_add bitser_add_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .sum_out(sum_out), .carry_out(carry_out)
);

// File: tb/tb_bitser_add.sv
module tb_bitser_add;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         busy, done, carry_out;
    logic [W-1:0] sum_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bitser_add #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy), .done(done), .sum_out(sum_out), .carry_out(carry_out)
    );

    function automatic logic [W:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic check(bit ok, string req, logic [W:0] act, logic [W:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; drives start at once. poke: start with other
    // operands in add cycle 2 (R6). chain: return in the done cycle (R9).
    task automatic do_add(logic [W-1:0] a, logic [W-1:0] b, bit poke, bit chain);
        logic [W:0] exp;
        bit busy_ok;
        exp   = ref_sum(a, b);
        start = 1'b1;
        a_in  = a;
        b_in  = b;
        @(negedge clk);
        start = 1'b0;
        busy_ok = 1'b1;
        for (int k = 0; k < W; k++) begin
            if (!busy || done) busy_ok = 1'b0;
            if (poke && k == 2) begin
                start = 1'b1;
                a_in  = ~a;
                b_in  = ~b;
            end
            if (poke && k == 3) start = 1'b0;
            @(negedge clk);
        end
        check(busy_ok, poke ? "R6 busy window" : "R2/R3 busy window", {W'(0), busy_ok}, 1);
        check(done && !busy, "R3 done after W cycles", {W'(0), done}, 1);
        check({carry_out, sum_out} == exp, poke ? "R6 result" : "R5 result",
              {carry_out, sum_out}, exp);
        if (!chain) begin
            @(negedge clk);
            check(!done, "R4 done single cycle", {W'(0), done}, 0);
            check({carry_out, sum_out} == exp, "R7 result held", {carry_out, sum_out}, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog R3 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && sum_out == '0 && !carry_out, "R1 reset state",
              {carry_out, sum_out}, 0);

        // Directed corner cases
        do_add('0, '0, 0, 0);
        do_add('1, 8'h01, 0, 0);             // full carry chain
        do_add('0, '0, 0, 0);                // R8: stale carry must not leak
        check(!carry_out, "R8 carry cleared", {W'(0), carry_out}, 0);
        do_add('1, '1, 0, 0);
        do_add(8'hAA, 8'h55, 0, 0);
        do_add(8'h80, 8'h80, 0, 0);          // carry from top bit only
        do_add(8'h0F, 8'h01, 0, 0);
        do_add(8'h3C, 8'hC3, 1, 0);          // R6 ignored start
        // R9: back-to-back via done cycle
        do_add(8'hFF, 8'hFF, 0, 1);
        do_add(8'h12, 8'h34, 0, 0);

        // Random pairs
        for (int i = 0; i < 40; i++) begin
            do_add(W'($urandom), W'($urandom), (i % 7) == 3, (i % 5) == 1);
        end

        // R1: reset in the middle of an addition
        start = 1'b1; a_in = 8'hF0; b_in = 8'h33;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && sum_out == '0 && !carry_out, "R1 reset mid-run",
              {carry_out, sum_out}, 0);
        repeat (W + 2) @(negedge clk);
        check(!done && !busy, "R1 no done after reset", {W'(0), done}, 0);
        do_add(8'h7F, 8'h81, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule